// File: doc/BRIEF.md
# Blue Alarm Detector

This block watches a received T1 bit stream for an alarm indication signal, the all-ones pattern sent in place of lost traffic. Every strobed bit is counted into consecutive, non-overlapping windows of a fixed bit count. At the 1.544 Mb/s line rate, 386 bits span 250 microseconds, which is two 193-bit frames. Within each window the block counts zeros. A window that ends with fewer zeros than a set limit (three by default) earns a clean verdict. The verdict is lost as soon as the limit is reached, without waiting for the window to close.

The alarm status is the clean verdict combined with the framer's loss-of-synchronization flag. It is high only while both hold and falls on the clock edge after either one fails. Framing recovery and alarm generation belong elsewhere. The block only needs the received bit, its strobe and the framer's flag.

Top module: `ais_detector`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, ais is low, and both the bit count and the zero count start at zero.
- R2: Only bits with rx_valid high are counted. Windows are consecutive, non-overlapping groups of WIN_BITS (default 386) strobed bits, and a cycle with rx_valid low changes nothing.
- R3: A bit with rx_bit = 0 is a zero. A window whose strobed bits hold fewer than ZERO_LIMIT (default 3) zeros sets the clean verdict on the clock edge that takes its last bit.
- R4: ais, registered, equals the clean verdict ANDed with los, and changes on the clock edge after the cause.
- R5: When the strobed zero that brings a window's count to ZERO_LIMIT arrives, the verdict clears and ais is low after that same clock edge, even mid-window.
- R6: When los goes low, ais is low after the next edge. When los rises while the verdict is clean, ais goes high after the next edge.
- R7: A clean verdict persists across following windows until one of them reaches ZERO_LIMIT zeros.
- R8: If the zero that reaches ZERO_LIMIT is also the last bit of a window, the verdict is not clean, and the next window starts counting from zero.
- R9: The zero count saturates at ZERO_LIMIT and never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received line bit |
| rx_valid | input | 1 | Strobe: rx_bit carries a new bit this cycle |
| los | input | 1 | Framer reports loss of synchronization |
| ais | output | 1 | Alarm indication signal status |

## Verification
Two events can land on one edge: the closing of a window and the arrival of the zero that reaches the limit. The bench provokes this by placing the limit-reaching zero on the final bit of a window. It then expects ais low after that edge. It then sends a window with two zeros and expects ais high at its end, which shows that the new window started from a zero count rather than inheriting the saturated one.

// File: rtl/ais_pkg.sv
package ais_pkg;
  // True when a bit this cycle is a strobed zero.
  function automatic logic is_zero(input logic valid, input logic bit_in);
    return valid && !bit_in;
  endfunction

  // True when a window closes on this strobed bit.
  function automatic logic closes_window(input logic valid, input int unsigned pos,
                                         input int unsigned win_bits);
    return valid && (pos == win_bits - 1);
  endfunction

  // Zero total after this bit stays below the limit.
  function automatic logic below_limit(input int unsigned zeros_before, input logic zero_now,
                                       input int unsigned limit);
    return (zeros_before + (zero_now ? 1 : 0)) < limit;
  endfunction
endpackage

// File: rtl/ais_window_ctr.sv
module ais_window_ctr #(
  parameter int unsigned WIN_BITS = 386,
  localparam int unsigned PW = $clog2(WIN_BITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  output logic win_end
);
  import ais_pkg::*;
  logic [PW-1:0] pos_q;

  assign win_end = closes_window(rx_valid, int'(pos_q), WIN_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n)        pos_q <= '0;
    else if (win_end)  pos_q <= '0;
    else if (rx_valid) pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/ais_zero_ctr.sv
module ais_zero_ctr #(
  parameter int unsigned ZERO_LIMIT = 3,
  localparam int unsigned ZW = $clog2(ZERO_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_bit,
  input  logic          win_end,
  output logic          zero_hit,
  output logic          win_clean,
  output logic [ZW-1:0] zero_cnt
);
  import ais_pkg::*;
  logic zero_now;

  assign zero_now  = is_zero(rx_valid, rx_bit);
  assign zero_hit  = zero_now && (int'(zero_cnt) == ZERO_LIMIT - 1);
  assign win_clean = win_end && below_limit(int'(zero_cnt), zero_now, ZERO_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      zero_cnt <= '0;
    else if (win_end)
      zero_cnt <= '0;
    else if (zero_now && (int'(zero_cnt) < ZERO_LIMIT))
      zero_cnt <= zero_cnt + 1'b1;
  end
endmodule

// File: rtl/ais_verdict.sv
module ais_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic win_end,
  input  logic win_clean,
  input  logic zero_hit,
  input  logic los,
  output logic win_ok,
  output logic ais
);
  logic ok_n;

  always_comb begin
    ok_n = win_ok;
    if (zero_hit)     ok_n = 1'b0;
    else if (win_end) ok_n = win_clean;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_ok <= 1'b0;
      ais    <= 1'b0;
    end else begin
      win_ok <= ok_n;
      ais    <= ok_n & los;
    end
  end
endmodule

// File: rtl/ais_detector.sv
module ais_detector #(
  parameter int unsigned WIN_BITS   = 386,
  parameter int unsigned ZERO_LIMIT = 3,
  localparam int unsigned ZW = $clog2(ZERO_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_valid,
  input  logic los,
  output logic ais
);
  logic          win_end;
  logic          zero_hit;
  logic          win_clean;
  logic          win_ok;
  logic [ZW-1:0] zero_cnt;

  ais_window_ctr #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .win_end(win_end)
  );

  ais_zero_ctr #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .win_end(win_end), .zero_hit(zero_hit), .win_clean(win_clean), .zero_cnt(zero_cnt)
  );

  ais_verdict u_verdict (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_clean(win_clean),
    .zero_hit(zero_hit), .los(los), .win_ok(win_ok), .ais(ais)
  );
endmodule

// File: rtl/ais_checker.sv
module ais_checker #(
  parameter int unsigned ZERO_LIMIT = 3,
  localparam int unsigned ZW = $clog2(ZERO_LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          los,
  input logic          ais,
  input logic          win_end,
  input logic          zero_hit,
  input logic          win_ok,
  input logic [ZW-1:0] zero_cnt
);
  AST_AIS_NEEDS_LOS: assert property (@(posedge clk) disable iff (!rst_n) ais |-> $past(los)); // R4
  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) zero_hit |=> !ais); // R5
  AST_LOS_DROP: assert property (@(posedge clk) disable iff (!rst_n) !los |=> !ais); // R6
  AST_OK_RISES_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(win_ok) |-> $past(win_end)); // R3
  AST_END_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) win_end |-> rx_valid); // R2
  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) int'(zero_cnt) <= ZERO_LIMIT); // R9
  AST_END_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) win_end |=> zero_cnt == '0); // R8
endmodule

bind ais_detector ais_checker #(.ZERO_LIMIT(ZERO_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .los(los), .ais(ais),
  .win_end(win_end), .zero_hit(zero_hit), .win_ok(win_ok), .zero_cnt(zero_cnt)
);

// File: tb/sim_ais_detector.sv
`timescale 1ns/1ps
module sim_ais_detector;
  localparam int WIN = 386;
  localparam int NV  = 8;
  // {zeros[3:0], los, expected ais at window end}
  localparam logic [5:0] VEC [NV] = '{
    {4'd0, 1'b1, 1'b1}, {4'd1, 1'b1, 1'b1}, {4'd2, 1'b1, 1'b1}, {4'd3, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b0}, {4'd0, 1'b0, 1'b0}, {4'd5, 1'b1, 1'b0}, {4'd1, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0, rx_bit = 1, rx_valid = 0, los = 0;
  wire  ais;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  ais_detector u0 (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
                   .los(los), .ais(ais));

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ais=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_valid = 1; rx_bit = b;
    @(negedge clk);
    rx_valid = 0; rx_bit = 1;
  endtask

  // Window with nz zeros at positions 0,7,14,...; idle gaps every 50 bits.
  task automatic send_window(input int nz);
    for (int i = 0; i < WIN; i++) begin
      if (i % 50 == 49) begin rx_bit = 0; @(negedge clk); rx_bit = 1; end
      send_bit(!((i % 7 == 0) && (i / 7 < nz)));
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: ais=%0b expected finish", ais);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ais, 1'b0, "R1 in reset");
    rst_n = 1; los = 1;
    @(negedge clk);
    check(ais, 1'b0, "R1 after reset");

    // R2: unstrobed zeros are not counted; verdict only at last bit
    for (int i = 0; i < WIN - 1; i++) begin
      rx_bit = 0; @(negedge clk); rx_bit = 1;
      send_bit(1'b1);
    end
    check(ais, 1'b0, "R2 before last bit");
    send_bit(1'b1);
    check(ais, 1'b1, "R2 R3 clean window ends");

    for (int v = 0; v < NV; v++) begin
      los = VEC[v][1];
      send_window(int'(VEC[v][5:2]));
      check(ais, VEC[v][0], $sformatf("R3 R4 vector %0d", v));
    end

    // R6: los toggling with clean verdict held
    los = 1; send_window(0);
    check(ais, 1'b1, "R7 clean held");
    los = 0; @(negedge clk);
    check(ais, 1'b0, "R6 los drop");
    los = 1; @(negedge clk);
    check(ais, 1'b1, "R6 los rise");

    // R5: third zero mid-window clears at once
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    check(ais, 1'b1, "R5 two zeros keep");
    send_bit(1'b0);
    check(ais, 1'b0, "R5 third zero clears");
    for (int i = 4; i < WIN; i++) send_bit(1'b1);
    check(ais, 1'b0, "R9 saturated window stays low");
    send_window(2);
    check(ais, 1'b1, "R7 R9 recover after full window");

    // R8: third zero on the last bit of a window
    send_bit(1'b0); send_bit(1'b0);
    for (int i = 2; i < WIN - 1; i++) send_bit(1'b1);
    check(ais, 1'b1, "R8 before last bit");
    send_bit(1'b0);
    check(ais, 1'b0, "R8 last-bit third zero");
    send_window(2);
    check(ais, 1'b1, "R8 next window from zero");

    // R1: reset mid-stream
    rst_n = 0; @(negedge clk);
    check(ais, 1'b0, "R1 reset clears");
    rst_n = 1;
    send_bit(1'b0); send_bit(1'b0);
    for (int i = 2; i < WIN; i++) send_bit(1'b1);
    check(ais, 1'b1, "R1 counters zero after reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule